// File: doc/BRIEF.md
# PCI configuration cycle sequencer

This block runs one PCI configuration read or write from start to finish. A request carries a bus number, a device/function byte, a register offset, an access size and write data. The block forms the configuration address and the window map value, then works through a fixed sequence on a small register-write port. First it widens memory window 0 so that it covers the region normally served by window 1. Then it points window 1 at configuration space and writes window 1's map. After that it makes one data access through the configuration window. Last, it puts window 1 back and shrinks window 0 again.

A write is always followed by a read of the same location before the windows are restored, so the write has landed before the memory map changes back. The data port is a plain read/write strobe pair. Read data is expected one cycle after the read strobe. The caller uses a start/busy/done handshake and receives the read data and an error flag together with the done pulse.

Top module: `cfg_cycle_seq`

## Requirements
- R1: A start pulse while idle is accepted and busy is high from the next cycle. Busy stays high until a single-cycle done pulse, and busy is low in the cycle after done. A start pulse while busy is ignored, and any request fields presented with it are not used.
- R2: On bus 0 with slot (device/function bits 7:3) of 12 or lower, the access address is: function (device/function bits 2:0) in bits 10:8, the offset in bits 7:0, and one bit set at position slot+11.
- R3: On bus 0 the map value has 1010 in bits 3:0 (cycle type 101 in bits 3:1, low-address pass bit 0 clear). For slots 13 to 20, bit slot-5 of the map value is also set. Slots 21 to 31 set no device bit, and on bus 0 with slot above 12 the address carries only the function and offset.
- R4: On a nonzero bus the access address holds the bus in bits 23:16, the device/function byte in bits 15:8 and the offset in bits 7:0. The map value is 0x000B.
- R5: A request whose bus, device/function or offset is above 255 gives done with err=1 in the first cycle after acceptance, with no register write and no data strobe. err stays 0 for a legal request.
- R6: Opening makes exactly three register writes, in this order. (a) Select 0 (window 0 base) gets 0x40000091: local base in bits 31:20, size code 9 (512 MB) in bits 7:4, enable in bit 0. (b) Select 1 (window 1 base) gets 0x61000041: size code 4 (16 MB). (c) Select 2 (window 1 map) gets the map value in bits 15:0.
- R7: Closing, after the data access, makes three register writes in this order. (a) Select 1 gets 0x50000081. (b) Select 2 gets 0x0000100C: the PCI address bits 31:20 in bits 15:4 and type 110 in bits 3:1. (c) Select 0 gets 0x40000081. Done follows in the next cycle.
- R8: A read makes one acc_rd strobe. A write makes one acc_wr strobe, followed in the next cycle by one acc_rd strobe at the same address.
- R9: Size code 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. acc_size carries the code. acc_wdata and rdata are zero-extended to the selected size, with rdata taken from acc_rdata one cycle after the last acc_rd.
- R10: During and after reset busy, done, err, all strobes and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start a request (accepted only while idle) |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 9 | Bus number; values above 255 are illegal |
| req_devfn | input | 9 | Device (7:3) and function (2:0); above 255 illegal |
| req_off | input | 9 | Register offset; above 255 illegal |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request flag, valid with done |
| rdata | output | 32 | Read (or write read-back) data, valid with done |
| reg_wr | output | 1 | Window register write strobe |
| reg_sel | output | 2 | 0 window 0 base, 1 window 1 base, 2 window 1 map |
| reg_wdata | output | 32 | Window register value |
| acc_rd | output | 1 | Configuration data read strobe |
| acc_wr | output | 1 | Configuration data write strobe |
| acc_addr | output | 24 | Offset inside the configuration window |
| acc_size | output | 2 | Size code of the data access |
| acc_wdata | output | 32 | Data for the write strobe |
| acc_rdata | input | 32 | Read data, valid the cycle after acc_rd |

## Verification
The assertions assume that the data port answers every read strobe with data in the following cycle. They also assume that request fields need to be valid only in the cycle where start is accepted. The bench keeps to both assumptions. It drives every input at the falling edge and answers each observed read strobe at once, with data built from the strobed address. It also holds acc_rdata until the next strobe. The one deliberate departure is a start pulse with an illegal bus sent mid-request, which the block must ignore.

// File: rtl/cfg_cycle_seq.sv
module cfg_cycle_seq #(
  parameter logic [31:0] NP_LOCAL  = 32'h4000_0000,
  parameter logic [31:0] PF_LOCAL  = 32'h5000_0000,
  parameter logic [31:0] CFG_LOCAL = 32'h6100_0000,
  parameter logic [31:0] PF_PCI    = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [8:0]  req_bus,
  input  logic [8:0]  req_devfn,
  input  logic [8:0]  req_off,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        reg_wr,
  output logic [1:0]  reg_sel,
  output logic [31:0] reg_wdata,
  output logic        acc_rd,
  output logic        acc_wr,
  output logic [23:0] acc_addr,
  output logic [1:0]  acc_size,
  output logic [31:0] acc_wdata,
  input  logic [31:0] acc_rdata
);
  localparam logic [31:0] BASE_MASK = 32'hFFF0_0000;
  localparam logic [31:0] W0_WIDE   = (NP_LOCAL & BASE_MASK) | 32'h91;
  localparam logic [31:0] W0_NORM   = (NP_LOCAL & BASE_MASK) | 32'h81;
  localparam logic [31:0] W1_CFG    = (CFG_LOCAL & BASE_MASK) | 32'h41;
  localparam logic [31:0] W1_PF     = (PF_LOCAL & BASE_MASK) | 32'h81;
  localparam logic [31:0] M1_PF     = {16'h0, PF_PCI[31:20], 4'hC};

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN0, S_BASE1, S_MAP1, S_XFER, S_CHK, S_CAP,
    S_REST1, S_RMAP1, S_CLOSE0, S_DONE
  } state_t;

  state_t      state;
  logic        q_wr;
  logic [7:0]  q_bus, q_devfn, q_off;
  logic [1:0]  q_size;
  logic [31:0] q_wdata;
  logic [23:0] cfg_addr;
  logic [15:0] cfg_map;
  logic [4:0]  slot;
  logic        bad_req;

  function automatic logic [31:0] fit(input logic [31:0] v, input logic [1:0] s);
    case (s)
      2'd0:    fit = {24'h0, v[7:0]};
      2'd1:    fit = {16'h0, v[15:0]};
      default: fit = v;
    endcase
  endfunction

  assign bad_req = req_bus[8] | req_devfn[8] | req_off[8];
  assign slot    = q_devfn[7:3];

  always_comb begin
    cfg_addr = '0;
    cfg_map  = 16'h000A;
    if (q_bus == 8'd0) begin
      cfg_addr[10:8] = q_devfn[2:0];
      if (slot <= 5'd12)
        cfg_addr[int'(slot) + 11] = 1'b1;
      else if (slot <= 5'd20)
        cfg_map[int'(slot) - 5] = 1'b1;
    end else begin
      cfg_addr[23:16] = q_bus;
      cfg_addr[15:8]  = q_devfn;
      cfg_map[0]      = 1'b1;
    end
    cfg_addr[7:0] = q_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      q_wr    <= 1'b0;
      q_bus   <= '0;
      q_devfn <= '0;
      q_off   <= '0;
      q_size  <= '0;
      q_wdata <= '0;
      err     <= 1'b0;
      rdata   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_start) begin
          q_wr    <= req_write;
          q_bus   <= req_bus[7:0];
          q_devfn <= req_devfn[7:0];
          q_off   <= req_off[7:0];
          q_size  <= req_size;
          q_wdata <= req_wdata;
          err     <= bad_req;
          rdata   <= '0;
          state   <= bad_req ? S_DONE : S_OPEN0;
        end
        S_OPEN0:  state <= S_BASE1;
        S_BASE1:  state <= S_MAP1;
        S_MAP1:   state <= S_XFER;
        S_XFER:   state <= q_wr ? S_CHK : S_CAP;
        S_CHK:    state <= S_CAP;
        S_CAP: begin
          rdata <= fit(acc_rdata, q_size);
          state <= S_REST1;
        end
        S_REST1:  state <= S_RMAP1;
        S_RMAP1:  state <= S_CLOSE0;
        S_CLOSE0: state <= S_DONE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy      = state != S_IDLE;
  assign done      = state == S_DONE;
  assign acc_wr    = state == S_XFER && q_wr;
  assign acc_rd    = (state == S_XFER && !q_wr) || state == S_CHK;
  assign acc_addr  = cfg_addr;
  assign acc_size  = q_size;
  assign acc_wdata = fit(q_wdata, q_size);

  always_comb begin
    reg_wr    = 1'b1;
    reg_sel   = 2'd0;
    reg_wdata = '0;
    case (state)
      S_OPEN0:  reg_wdata = W0_WIDE;
      S_BASE1:  begin reg_sel = 2'd1; reg_wdata = W1_CFG; end
      S_MAP1:   begin reg_sel = 2'd2; reg_wdata = {16'h0, cfg_map}; end
      S_REST1:  begin reg_sel = 2'd1; reg_wdata = W1_PF; end
      S_RMAP1:  begin reg_sel = 2'd2; reg_wdata = M1_PF; end
      S_CLOSE0: reg_wdata = W0_NORM;
      default:  reg_wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_cycle_seq_chk.sv
module cfg_cycle_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_start,
  input logic [8:0]  req_bus,
  input logic [8:0]  req_devfn,
  input logic [8:0]  req_off,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic [23:0] acc_addr
);
  // R1
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  // R5
  illegal_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy && (req_bus[8] || req_devfn[8] || req_off[8]))
    |=> done && err && !reg_wr && !acc_rd && !acc_wr);

  // R6
  open_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[7:4] == 4'h9)
    |=> reg_wr && reg_sel == 2'd1 && reg_wdata[7:4] == 4'h4);

  // R7
  close_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && reg_wdata[7:4] == 4'h8) |=> done);

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> acc_rd && acc_addr == $past(acc_addr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_wr && !acc_rd && !acc_wr && !done);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, acc_rd, acc_wr}));
endmodule

bind cfg_cycle_seq cfg_cycle_seq_chk u_chk (.*);

// File: tb/test_cfg_cycle_seq.sv
module test_cfg_cycle_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_write = 1'b0;
  logic [8:0]  req_bus = '0, req_devfn = '0, req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err, reg_wr, acc_rd, acc_wr;
  logic [31:0] rdata, reg_wdata, acc_wdata;
  logic [1:0]  reg_sel, acc_size;
  logic [23:0] acc_addr;
  logic [31:0] acc_rdata = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  cfg_cycle_seq i_cfg_cycle_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fit(input logic [31:0] v, input logic [1:0] s);
    if (s == 2'd0) return v & 32'hFF;
    if (s == 2'd1) return v & 32'hFFFF;
    return v;
  endfunction

  function automatic logic [31:0] want_addr(input logic [7:0] b, input logic [7:0] df, input logic [7:0] o);
    logic [31:0] a;
    int s;
    s = int'(df >> 3);
    if (b != 0) return {8'h0, b, df, o};
    a = {21'h0, df[2:0], o};
    if (s <= 12) a = a | (32'h1 << (s + 11));
    return a;
  endfunction

  function automatic logic [31:0] want_map(input logic [7:0] b, input logic [7:0] df);
    int s;
    s = int'(df >> 3);
    if (b != 0) return 32'h0000_000B;
    if (s >= 13 && s <= 20) return 32'hA | (32'h1 << (s - 5));
    return 32'h0000_000A;
  endfunction

  function automatic string addr_tag(input logic [7:0] b, input logic [7:0] df);
    if (b != 0) return "R4";
    if (df[7:3] <= 5'd12) return "R2";
    return "R3";
  endfunction

  // event kinds: 1 register write, 2 data write, 3 data read
  int          ek[16], xk[16];
  logic [31:0] ea[16], ed[16], xa[16], xd[16];

  task automatic run_req(input logic wr, input logic [8:0] b, input logic [8:0] df,
                         input logic [8:0] o, input logic [1:0] sz,
                         input logic [31:0] wd, input bit intrude);
    int n = 0, nx = 0;
    bit got = 0, illegal;
    logic [31:0] a, got_rd, got_err, last_rd;
    string t;
    illegal = b[8] | df[8] | o[8];
    a = want_addr(b[7:0], df[7:0], o[7:0]);
    t = addr_tag(b[7:0], df[7:0]);
    last_rd = {8'hC3, a[23:0]};
    @(negedge clk);
    req_start = 1; req_write = wr; req_bus = b; req_devfn = df;
    req_off = o; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_start = 0;
    check("R1 busy after start", {31'h0, busy}, 32'h1);
    for (int c = 0; c < 40; c++) begin
      if (reg_wr && n < 16) begin ek[n] = 1; ea[n] = {30'h0, reg_sel}; ed[n] = reg_wdata; n++; end
      if (acc_wr && n < 16) begin ek[n] = 2; ea[n] = {8'h0, acc_addr}; ed[n] = acc_wdata; n++; end
      if (acc_rd && n < 16) begin
        ek[n] = 3; ea[n] = {8'h0, acc_addr}; ed[n] = {30'h0, acc_size}; n++;
        acc_rdata = {8'hC3, acc_addr};
      end
      if (done) begin got = 1; got_rd = rdata; got_err = {31'h0, err}; break; end
      if (intrude && c == 2) begin
        req_start = 1; req_bus = 9'd300; req_write = ~wr;
      end else req_start = 0;
      @(negedge clk);
    end
    req_start = 0;
    check("R1 done seen", {31'h0, got}, 32'h1);
    if (illegal) begin
      check("R5 err with done", got_err, 32'h1);
    end else begin
      xk[0] = 1; xa[0] = 0; xd[0] = 32'h4000_0091;
      xk[1] = 1; xa[1] = 1; xd[1] = 32'h6100_0041;
      xk[2] = 1; xa[2] = 2; xd[2] = want_map(b[7:0], df[7:0]);
      nx = 3;
      if (wr) begin xk[nx] = 2; xa[nx] = a; xd[nx] = fit(wd, sz); nx++; end
      xk[nx] = 3; xa[nx] = a; xd[nx] = {30'h0, sz}; nx++;
      xk[nx] = 1; xa[nx] = 1; xd[nx] = 32'h5000_0081; nx++;
      xk[nx] = 1; xa[nx] = 2; xd[nx] = 32'h0000_100C; nx++;
      xk[nx] = 1; xa[nx] = 0; xd[nx] = 32'h4000_0081; nx++;
      check("R5 err clear on legal", got_err, 32'h0);
      check("R9 rdata sized", got_rd, fit(last_rd, sz));
    end
    check(illegal ? "R5 event count" : "R8 event count", n, nx);
    for (int i = 0; i < nx && i < n; i++) begin
      string et;
      et = (i < 3) ? "R6" : (i >= nx - 3) ? "R7" : "R8";
      check({et, " kind"}, ek[i], xk[i]);
      check({(xk[i] == 1) ? et : t, " sel/addr"}, ea[i], xa[i]);
      check({(i == 2) ? "R3 R4 map" : (xk[i] == 1) ? et : "R9", " data"}, ed[i], xd[i]);
    end
    @(negedge clk);
    check("R1 busy low after done", {31'h0, busy}, 32'h0);
    check("R1 done single pulse", {31'h0, done}, 32'h0);
  endtask

  // {write, bus[8:0], devfn[8:0], off[8:0], size[1:0]}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 9'd0,   9'h000, 9'h000, 2'd2},
    {1'b0, 9'd0,   9'h063, 9'h010, 2'd1},
    {1'b1, 9'd0,   9'h069, 9'h004, 2'd0},
    {1'b0, 9'd0,   9'h0A7, 9'h0FC, 2'd3},
    {1'b0, 9'd0,   9'h0A8, 9'h008, 2'd2},
    {1'b1, 9'd5,   9'h02A, 9'h03C, 2'd2},
    {1'b0, 9'd255, 9'h0FF, 9'h0FF, 2'd0},
    {1'b0, 9'd256, 9'h000, 9'h000, 2'd2},
    {1'b1, 9'd0,   9'h100, 9'h000, 2'd2},
    {1'b0, 9'd1,   9'h008, 9'h100, 2'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", {31'h0, busy}, 32'h0);
    check("R10 done", {31'h0, done}, 32'h0);
    check("R10 err", {31'h0, err}, 32'h0);
    check("R10 rdata", rdata, 32'h0);
    check("R10 strobes", {29'h0, reg_wr, acc_rd, acc_wr}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle after reset", {31'h0, busy}, 32'h0);

    for (int v = 0; v < NV; v++)
      run_req(VEC[v][29], VEC[v][28:20], VEC[v][19:11], VEC[v][10:2],
              VEC[v][1:0], 32'hA1B2_C3D4 ^ v, 1'b0);

    // R1 start while busy ignored (illegal request poked mid-run)
    run_req(1'b0, 9'd0, 9'h018, 9'h020, 2'd2, 32'h0, 1'b1);
    run_req(1'b1, 9'd2, 9'h0F1, 9'h044, 2'd1, 32'h5566_7788, 1'b1);
    // R5 legal after illegal clears err
    run_req(1'b0, 9'd300, 9'd300, 9'd300, 2'd2, 32'h0, 1'b0);
    run_req(1'b0, 9'd0, 9'h060, 9'h000, 2'd2, 32'h0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule